// File: doc/BRIEF.md
# Interrupt Level Priority Arbiter

This block chooses which interrupt level a processor core should take next. Each cycle it forms a pending set from two sources: fifteen external level lines, and the level bits of a software-interrupt register. The two timer-match bits of that register do not map to their own levels; either one raises level 14. Only levels strictly above the current processor interrupt level (PIL) can win. The scan runs from level 15 down, and level 15 has no privilege over the others. The winner becomes a 9-bit trap-type index with the value 0x40 plus the level number.

The decision is held in a three-state machine. `ST_IDLE` holds no index and no request. `ST_ARMED` holds an index with the request flag high. `ST_HELD` holds an index whose request has been acknowledged. The transitions are as follows:
- T_RAISE goes to `ST_ARMED` with a new index.
- T_ACK goes from `ST_ARMED` to `ST_HELD`.
- T_CLEAR goes to `ST_IDLE` when nothing is pending.
- T_STAY keeps the state in every other case.

A raise is blocked while interrupts are disabled. It is also blocked while a trap already in progress (trap level nonzero) has a trap type above the candidate. A combinational take signal tells the core that the held index may be delivered now.

Top module: `ilp_arbiter`

## Requirements
- R1: A synchronous active-high reset puts the arbiter in `ST_IDLE`, with `irq_req` = 0 and `irq_tt` = 0 after the clock edge.
- R2: The pending set is formed from `ext_lvl[n]` and `soft_int[n]` for levels n = 1..15. Bit 0 (tick match) and bit 16 (system-tick match) of `soft_int` do not map to levels of their own; if either is set, level 14 is pending.
- R3: When the pending set is empty, the next edge clears `irq_req` and `irq_tt` to 0 (T_CLEAR). This happens whether or not interrupts are enabled.
- R4: While `ie` = 0 and something is pending, `irq_tt` and the request keep their values, except that `ack` may still clear the request.
- R5: The candidate is the highest pending level strictly greater than `pil`. Level 15 is masked by `pil` = 15 like every other level. When no level qualifies, the state is kept.
- R6: The index is `0x40 | level`: the level sits in bits [3:0] and the type 0x4 sits in bits [8:4].
- R7: When `tl` is nonzero and `cur_tt` is greater than the candidate index, no raise happens. With `tl` = 0, or with `cur_tt` not above the candidate, the raise proceeds.
- R8: A raise (T_RAISE: the index loads and `irq_req` goes to 1) occurs only when the candidate differs from the index already held. An acknowledged index that is still pending is not raised again.
- R9: `ack` clears `irq_req` on the next edge (T_ACK). If a raise happens in the same cycle, the raise wins and `irq_req` stays 1 with the new index.
- R10: `irq_take` is 1 exactly when `irq_req` = 1, `ie` = 1, `irq_tt` is nonzero and the level in `irq_tt[3:0]` is greater than the present `pil`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ext_lvl | input | 15 | External level lines, bit n = level n (indices 15:1) |
| soft_int | input | 17 | Software-interrupt register: bit 0 tick match, bits 15:1 levels, bit 16 system-tick match |
| pil | input | 4 | Current processor interrupt level |
| ie | input | 1 | Interrupt enable |
| tl | input | 3 | Current trap level |
| cur_tt | input | 9 | Trap type of the trap in progress |
| ack | input | 1 | Request taken, clears the request flag |
| irq_req | output | 1 | Registered interrupt request flag |
| irq_tt | output | 9 | Registered trap-type index |
| irq_take | output | 1 | Held index may be delivered now |

## Verification
The hardest situation to reach is a raise suppressed by an active trap. It needs a held index, a nonzero trap level and a `cur_tt` above the new candidate, all at once. The stimulus table first arms level 15, then presents level 10 under trap level 1 with `cur_tt` = 0x4F, and checks that the old index survives. A further vector puts a candidate equal to `cur_tt` at trap level 2, and another leaves it blocked by a larger type. A directed test drives an acknowledge and a new candidate into the same cycle to show that the raise wins.

// File: rtl/ilp_pkg.sv
package ilp_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_ARMED = 2'd1,
        ST_HELD  = 2'd2
    } ilp_state_e;

endpackage

// File: rtl/ilp_merge.sv
module ilp_merge #(
    parameter int LEVELS    = 16,
    parameter int SOFT_W    = 17,
    parameter int TICK_BIT  = 0,
    parameter int STICK_BIT = 16,
    parameter int FOLD_LVL  = 14
) (
    input  logic [LEVELS-1:1] ext_lvl,
    input  logic [SOFT_W-1:0] soft_int,
    output logic [LEVELS-1:0] pend
);

    logic timer_hit;

    assign timer_hit = soft_int[TICK_BIT] | soft_int[STICK_BIT];
    assign pend[0]   = 1'b0;

    for (genvar i = 1; i < LEVELS; i++) begin : g_lvl
        logic direct;
        if (i == TICK_BIT || i == STICK_BIT || i >= SOFT_W) begin : g_ext_only
            assign direct = ext_lvl[i];
        end else begin : g_both
            assign direct = ext_lvl[i] | soft_int[i];
        end
        if (i == FOLD_LVL) begin : g_fold
            assign pend[i] = direct | timer_hit;
        end else begin : g_plain
            assign pend[i] = direct;
        end
    end

endmodule

// File: rtl/ilp_select.sv
module ilp_select #(
    parameter int LEVELS = 16,
    localparam int LVL_W = $clog2(LEVELS)
) (
    input  logic [LEVELS-1:0] pend,
    input  logic [LVL_W-1:0]  pil,
    output logic              hit,
    output logic [LVL_W-1:0]  lvl
);

    logic [LEVELS-1:0] elig;

    for (genvar i = 0; i < LEVELS; i++) begin : g_elig
        assign elig[i] = pend[i] && ((LVL_W+1)'(i) > {1'b0, pil});
    end

    always_comb begin
        hit = 1'b0;
        lvl = '0;
        for (int i = 0; i < LEVELS; i++) begin
            if (elig[i]) begin
                hit = 1'b1;
                lvl = LVL_W'(i);
            end
        end
    end

endmodule

// File: rtl/ilp_arbiter.sv
module ilp_arbiter
    import ilp_pkg::*;
#(
    parameter int              LEVELS    = 16,
    parameter int              SOFT_W    = 17,
    parameter int              TICK_BIT  = 0,
    parameter int              STICK_BIT = 16,
    parameter int              FOLD_LVL  = 14,
    parameter int              TL_W      = 3,
    parameter int              TT_W      = 9,
    parameter logic [TT_W-1:0] EXT_BASE  = 9'h040,
    localparam int             LVL_W     = $clog2(LEVELS)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [LEVELS-1:1] ext_lvl,
    input  logic [SOFT_W-1:0] soft_int,
    input  logic [LVL_W-1:0]  pil,
    input  logic              ie,
    input  logic [TL_W-1:0]   tl,
    input  logic [TT_W-1:0]   cur_tt,
    input  logic              ack,
    output logic              irq_req,
    output logic [TT_W-1:0]   irq_tt,
    output logic              irq_take
);

    logic [LEVELS-1:0] pend;
    logic              hit;
    logic [LVL_W-1:0]  lvl;
    logic [TT_W-1:0]   cand_tt;
    logic              empty;
    logic              suppress;
    logic              raise;

    ilp_state_e        state_q, state_d;
    logic [TT_W-1:0]   tt_q, tt_d;

    ilp_merge #(
        .LEVELS(LEVELS), .SOFT_W(SOFT_W), .TICK_BIT(TICK_BIT),
        .STICK_BIT(STICK_BIT), .FOLD_LVL(FOLD_LVL)
    ) u_merge (
        .ext_lvl (ext_lvl),
        .soft_int(soft_int),
        .pend    (pend)
    );

    ilp_select #(.LEVELS(LEVELS)) u_select (
        .pend(pend),
        .pil (pil),
        .hit (hit),
        .lvl (lvl)
    );

    assign cand_tt  = EXT_BASE | TT_W'(lvl);
    assign empty    = (pend == '0);
    assign suppress = (tl != '0) && (cur_tt > cand_tt);
    assign raise    = ie && hit && !suppress && (cand_tt != tt_q);

    // next-state: T_CLEAR, T_RAISE, T_ACK, T_STAY
    always_comb begin
        state_d = state_q;
        tt_d    = tt_q;
        unique case (state_q)
            ST_IDLE: begin
                if (!empty && raise) begin
                    state_d = ST_ARMED;
                    tt_d    = cand_tt;
                end
            end
            ST_ARMED: begin
                if (empty) begin
                    state_d = ST_IDLE;
                    tt_d    = '0;
                end else if (raise) begin
                    state_d = ST_ARMED;
                    tt_d    = cand_tt;
                end else if (ack) begin
                    state_d = ST_HELD;
                end
            end
            ST_HELD: begin
                if (empty) begin
                    state_d = ST_IDLE;
                    tt_d    = '0;
                end else if (raise) begin
                    state_d = ST_ARMED;
                    tt_d    = cand_tt;
                end
            end
            default: begin
                state_d = ST_IDLE;
                tt_d    = '0;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            tt_q    <= '0;
        end else begin
            state_q <= state_d;
            tt_q    <= tt_d;
        end
    end

    always_comb begin
        irq_req  = (state_q == ST_ARMED);
        irq_tt   = tt_q;
        irq_take = irq_req && ie && (tt_q != '0) &&
                   ((tt_q[TT_W-1:LVL_W] != EXT_BASE[TT_W-1:LVL_W]) ||
                    (tt_q[LVL_W-1:0] > pil));
    end

endmodule

// File: rtl/ilp_arbiter_chk.sv
module ilp_arbiter_chk #(
    parameter int LEVELS = 16,
    parameter int SOFT_W = 17,
    parameter int TL_W   = 3,
    parameter int TT_W   = 9,
    localparam int LVL_W = $clog2(LEVELS)
) (
    input logic              clk,
    input logic              rst,
    input logic [LEVELS-1:1] ext_lvl,
    input logic [SOFT_W-1:0] soft_int,
    input logic [LVL_W-1:0]  pil,
    input logic              ie,
    input logic [TL_W-1:0]   tl,
    input logic [TT_W-1:0]   cur_tt,
    input logic              ack,
    input logic              irq_req,
    input logic [TT_W-1:0]   irq_tt,
    input logic              irq_take
);

    logic none_pending;
    assign none_pending = (ext_lvl == '0) && (soft_int == '0);

    assert_reset_clears_R1: assert property (@(posedge clk)
        rst |=> (!irq_req && irq_tt == '0));

    assert_empty_clears_R3: assert property (@(posedge clk) disable iff (rst)
        none_pending |=> (!irq_req && irq_tt == '0));

    assert_disabled_holds_R4: assert property (@(posedge clk) disable iff (rst)
        (!none_pending && !ie) |=> $stable(irq_tt));

    assert_index_form_R6: assert property (@(posedge clk) disable iff (rst)
        (irq_tt != '0) |-> (irq_tt[TT_W-1:LVL_W] == 'h4 && irq_tt[LVL_W-1:0] != '0));

    assert_raise_new_index_R8: assert property (@(posedge clk) disable iff (rst)
        $rose(irq_req) |-> (irq_tt != $past(irq_tt)));

    assert_ack_clears_R9: assert property (@(posedge clk) disable iff (rst)
        (irq_req && ack && !ie) |=> !irq_req);

    assert_take_gated_R10: assert property (@(posedge clk) disable iff (rst)
        irq_take |-> (irq_req && ie && irq_tt[LVL_W-1:0] > pil));

    assert_suppress_holds_R7: assert property (@(posedge clk) disable iff (rst)
        (!none_pending && tl != '0 && cur_tt == '1) |=> $stable(irq_tt));

endmodule

bind ilp_arbiter ilp_arbiter_chk #(
    .LEVELS(LEVELS), .SOFT_W(SOFT_W), .TL_W(TL_W), .TT_W(TT_W)
) u_chk (
    .clk(clk), .rst(rst), .ext_lvl(ext_lvl), .soft_int(soft_int),
    .pil(pil), .ie(ie), .tl(tl), .cur_tt(cur_tt), .ack(ack),
    .irq_req(irq_req), .irq_tt(irq_tt), .irq_take(irq_take)
);

// File: tb/tb_ilp_arbiter.sv
module tb_ilp_arbiter;

    logic        clk = 1'b0;
    logic        rst;
    logic [15:1] ext_lvl;
    logic [16:0] soft_int;
    logic [3:0]  pil;
    logic        ie;
    logic [2:0]  tl;
    logic [8:0]  cur_tt;
    logic        ack;
    logic        irq_req;
    logic [8:0]  irq_tt;
    logic        irq_take;

    int n_checks = 0;
    int n_fail   = 0;

    always #4 clk = ~clk;

    ilp_arbiter dut (
        .clk(clk), .rst(rst), .ext_lvl(ext_lvl), .soft_int(soft_int),
        .pil(pil), .ie(ie), .tl(tl), .cur_tt(cur_tt), .ack(ack),
        .irq_req(irq_req), .irq_tt(irq_tt), .irq_take(irq_take)
    );

    // {ext16, soft17, pil4, ie1, tl3, cur_tt9, ack1 | req1, tt9, take1}
    localparam int NV = 19;
    localparam logic [61:0] VEC [0:NV-1] = '{
        {16'h0000, 17'h00000, 4'd0,  1'b1, 3'd0, 9'h000, 1'b0, 1'b0, 9'h000, 1'b0},
        {16'h0020, 17'h00000, 4'd0,  1'b1, 3'd0, 9'h000, 1'b0, 1'b1, 9'h045, 1'b1},
        {16'h0020, 17'h00000, 4'd0,  1'b1, 3'd0, 9'h000, 1'b1, 1'b0, 9'h045, 1'b0},
        {16'h0020, 17'h00000, 4'd0,  1'b1, 3'd0, 9'h000, 1'b0, 1'b0, 9'h045, 1'b0},
        {16'h0220, 17'h00000, 4'd0,  1'b1, 3'd0, 9'h000, 1'b0, 1'b1, 9'h049, 1'b1},
        {16'h0220, 17'h00000, 4'd9,  1'b1, 3'd0, 9'h000, 1'b0, 1'b1, 9'h049, 1'b0},
        {16'h1220, 17'h00000, 4'd3,  1'b0, 3'd0, 9'h000, 1'b0, 1'b1, 9'h049, 1'b0},
        {16'h1220, 17'h00000, 4'd3,  1'b1, 3'd0, 9'h000, 1'b0, 1'b1, 9'h04C, 1'b1},
        {16'h0000, 17'h00001, 4'd0,  1'b1, 3'd0, 9'h000, 1'b0, 1'b1, 9'h04E, 1'b1},
        {16'h0000, 17'h10000, 4'd0,  1'b1, 3'd0, 9'h000, 1'b1, 1'b0, 9'h04E, 1'b0},
        {16'h0000, 17'h00008, 4'd0,  1'b1, 3'd0, 9'h000, 1'b0, 1'b1, 9'h043, 1'b1},
        {16'h0000, 17'h08000, 4'd15, 1'b1, 3'd0, 9'h000, 1'b0, 1'b1, 9'h043, 1'b0},
        {16'h0000, 17'h08000, 4'd14, 1'b1, 3'd0, 9'h000, 1'b0, 1'b1, 9'h04F, 1'b1},
        {16'h0400, 17'h00000, 4'd0,  1'b1, 3'd1, 9'h04F, 1'b0, 1'b1, 9'h04F, 1'b1},
        {16'h0400, 17'h00000, 4'd0,  1'b1, 3'd0, 9'h04F, 1'b0, 1'b1, 9'h04A, 1'b1},
        {16'h0800, 17'h00000, 4'd0,  1'b1, 3'd2, 9'h04B, 1'b0, 1'b1, 9'h04B, 1'b1},
        {16'h2000, 17'h00000, 4'd0,  1'b1, 3'd2, 9'h060, 1'b0, 1'b1, 9'h04B, 1'b1},
        {16'h0000, 17'h00000, 4'd0,  1'b0, 3'd0, 9'h000, 1'b0, 1'b0, 9'h000, 1'b0},
        {16'h0002, 17'h00000, 4'd0,  1'b1, 3'd0, 9'h000, 1'b0, 1'b1, 9'h041, 1'b1}
    };

    string vtag [0:NV-1];

    task automatic chk(input string tag, input string what, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic check_out(input string tag, input logic req, input logic [8:0] tt, input logic take);
        chk(tag, "irq_req", int'(irq_req), int'(req));
        chk(tag, "irq_tt", int'(irq_tt), int'(tt));
        chk(tag, "irq_take", int'(irq_take), int'(take));
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        vtag = '{"R3", "R6", "R9", "R8", "R5", "R10", "R4", "R5", "R2", "R2",
                 "R2", "R5", "R5", "R7", "R7", "R7", "R7", "R3", "R6"};
        rst = 1'b1; ext_lvl = '0; soft_int = '0; pil = '0; ie = 1'b0;
        tl = '0; cur_tt = '0; ack = 1'b0;
        @(negedge clk);
        step();
        check_out("R1", 1'b0, 9'h000, 1'b0);
        rst = 1'b0;

        for (int k = 0; k < NV; k++) begin
            ext_lvl  = VEC[k][61:47];
            soft_int = VEC[k][45:29];
            pil      = VEC[k][28:25];
            ie       = VEC[k][24];
            tl       = VEC[k][23:21];
            cur_tt   = VEC[k][20:12];
            ack      = VEC[k][11];
            step();
            check_out(vtag[k], VEC[k][10], VEC[k][9:1], VEC[k][0]);
        end

        // R9: ack and a new candidate together, raise wins
        ext_lvl = 15'h0002; pil = 4'd0; ie = 1'b1; tl = '0; cur_tt = '0; ack = 1'b1;
        step();
        check_out("R9", 1'b1, 9'h042, 1'b1);

        // R9 with R4: ack while disabled clears request, index kept
        ie = 1'b0;
        step();
        check_out("R9", 1'b0, 9'h042, 1'b0);
        ack = 1'b0;

        // R2: system-tick bit alone yields level 14
        ie = 1'b1; ext_lvl = '0; soft_int = 17'h10000;
        step();
        check_out("R2", 1'b1, 9'h04E, 1'b1);

        // R1: reset in mid-run
        ext_lvl = 15'h0040; soft_int = '0;
        step();
        check_out("R6", 1'b1, 9'h047, 1'b1);
        rst = 1'b1;
        step();
        check_out("R1", 1'b0, 9'h000, 1'b0);
        rst = 1'b0;

        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule